// File: doc/BRIEF.md
# Flash Erase/Write Unlock Controller

This block sits between software-visible registers and an on-chip flash array, and it guards erase and write access to that array. Software reaches it through a byte-wide register port: one control register, a two-byte array address, and three 16-bit key/data pairs, each made of a low byte and a high byte. Erase and write stay locked until software runs a timed unlock procedure. Software selects the unlock mode and sets the trigger bit, which starts an internal timer. It must then place three fixed 16-bit keys in the three pairs before the timer runs out. Only hardware can set the resulting status bit. Software can clear that bit to lock the array again.

Toward the array, the block issues a one-cycle request that carries an operation code, the address and the write data. It then waits for a done pulse. A write or a page erase goes out only when the status bit is set. A read goes out only when read enable is set and the read mode is selected. Read results land in the first pair. A start bit that is refused clears itself one cycle later, and no request goes out.

Top module: `flash_guard`

## Requirements
- R1: After reset, every register reads 0 (offsets 0 to 8) and `fl_req` is 0.
- R2: Control is written with mode 110 (bits 6:4) and trigger bit 0 set. If pair 1 (offsets 3 low, 4 high) then holds 0x55AA, pair 2 (5, 6) holds 0xA55A and pair 3 (7, 8) holds 0x5AA5 while the trigger is still high, then the status bit (bit 7) becomes 1 and the trigger bit clears.
- R3: The trigger bit reads 1 for exactly TMO cycles after the trigger write, then hardware clears it. Keys written after that leave the status bit at 0.
- R4: A control write of 1 to bit 7 does not set the status bit. A control write of 0 to bit 7 clears it.
- R5: If the write-start bit (bit 1) is set while the block is locked, it reads 1 for one cycle, then clears, and no request is issued.
- R6: When unlocked, a control write with the write-start bit set and mode 000 issues a one-cycle `fl_req` with `fl_op`=00, `fl_addr` taken from offsets 2:1 and `fl_wdata` taken from pair 1. The write-start bit stays 1 until `fl_done` arrives, then clears.
- R7: When unlocked, mode 001 with the write-start bit set issues a page erase request with `fl_op`=01.
- R8: A control write that sets the read-start bit (bit 2) with read enable (bit 3) and mode 011 issues a request with `fl_op`=10. `fl_rdata` at `fl_done` is latched into pair 1. If read enable is clear, no request is issued.
- R9: Reserved modes (010, 100, 101, 111) issue no request and do not start the timer.
- R10: A trigger write while the timer runs restarts the full TMO-cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read offset |
| rd_data | output | 8 | Register read data (combinational) |
| fl_req | output | 1 | One-cycle operation request to array |
| fl_op | output | 2 | Operation: 00 write, 01 page erase, 10 read |
| fl_addr | output | 16 | Array address |
| fl_wdata | output | 16 | Array write data |
| fl_rdata | input | 16 | Array read data, valid with fl_done |
| fl_done | input | 1 | Operation complete pulse |

## Verification
The situations hardest to reach from the ports are the edges of the timer window: a trigger that expires on its exact TMO-th cycle, and a retrigger partway through that has to stretch the window. The stimulus reaches them by writing the trigger at a known clock edge and reading the control register exactly one cycle before and one cycle after the expected clear. Before any trigger, it puts non-matching values in the pairs, so that a key match cannot end the window early. The bench then breaks one key byte and restores it inside a window, which shows that the match check runs on each cycle and not only at trigger time.

// File: rtl/fg_pkg.sv
package fg_pkg;
  localparam int RAW = 4;
  localparam logic [RAW-1:0] OFS_CTRL  = 4'd0;
  localparam logic [RAW-1:0] OFS_ALO   = 4'd1;
  localparam logic [RAW-1:0] OFS_AHI   = 4'd2;
  localparam logic [RAW-1:0] OFS_PAIR0 = 4'd3;

  localparam int B_TRIG = 0;
  localparam int B_WGO  = 1;
  localparam int B_RGO  = 2;
  localparam int B_REN  = 3;
  localparam int B_MLO  = 4;
  localparam int B_MHI  = 6;
  localparam int B_STAT = 7;

  localparam logic [2:0] MD_WRITE  = 3'b000;
  localparam logic [2:0] MD_ERASE  = 3'b001;
  localparam logic [2:0] MD_READ   = 3'b011;
  localparam logic [2:0] MD_UNLOCK = 3'b110;

  localparam logic [1:0] OP_WRITE = 2'b00;
  localparam logic [1:0] OP_ERASE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
endpackage

// File: rtl/fg_regs.sv
module fg_regs
  import fg_pkg::*;
#(
  parameter int NPAIR = 3
) (
  input  logic                   clk,
  input  logic                   rst_sn,
  input  logic                   wr_en,
  input  logic [RAW-1:0]         wr_addr,
  input  logic [7:0]             wr_data,
  input  logic                   ld_en,
  input  logic [15:0]            ld_data,
  output logic [2:0]             mode,
  output logic                   rd_en,
  output logic [15:0]            faddr,
  output logic [NPAIR-1:0][15:0] pair
);
  localparam int NB = 2 + 2 * NPAIR;

  logic [7:0] byte_q [NB];
  logic [2:0] mode_q, mode_d;
  logic       ren_q, ren_d;
  logic       ctrl_we;

  assign ctrl_we = wr_en && (wr_addr == OFS_CTRL);

  always_comb begin
    mode_d = mode_q;
    ren_d  = ren_q;
    if (ctrl_we) begin
      mode_d = wr_data[B_MHI:B_MLO];
      ren_d  = wr_data[B_REN];
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mode_q <= '0;
      ren_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ren_q  <= ren_d;
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic       we, ld, en;
    logic [7:0] d;
    assign we = wr_en && (wr_addr == RAW'(i + 1));
    if (i == 2) begin : g_ldlo
      assign ld = ld_en;
      assign d  = ld_en ? ld_data[7:0] : wr_data;
    end else if (i == 3) begin : g_ldhi
      assign ld = ld_en;
      assign d  = ld_en ? ld_data[15:8] : wr_data;
    end else begin : g_plain
      assign ld = 1'b0;
      assign d  = wr_data;
    end
    assign en = we || ld;
    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)  byte_q[i] <= '0;
      else if (en)  byte_q[i] <= d;
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign pair[p] = {byte_q[2*p+3], byte_q[2*p+2]};
  end

  assign faddr = {byte_q[1], byte_q[0]};
  assign mode  = mode_q;
  assign rd_en = ren_q;
endmodule

// File: rtl/fg_unlock.sv
module fg_unlock
  import fg_pkg::*;
#(
  parameter int          TMO  = 64,
  parameter logic [15:0] KEY1 = 16'h55AA,
  parameter logic [15:0] KEY2 = 16'hA55A,
  parameter logic [15:0] KEY3 = 16'h5AA5
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             ctrl_we,
  input  logic [7:0]       wr_data,
  input  logic [2:0]       mode,
  input  logic [2:0][15:0] pair,
  output logic             trig,
  output logic             unlocked
);
  localparam int CW = $clog2(TMO + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          trig_q, trig_d, unl_q, unl_d;
  logic          trig_set, keys_ok, cnt_en;

  assign trig_set = ctrl_we && wr_data[B_TRIG] && (wr_data[B_MHI:B_MLO] == MD_UNLOCK);
  assign keys_ok  = (pair[0] == KEY1) && (pair[1] == KEY2) && (pair[2] == KEY3)
                    && (mode == MD_UNLOCK);
  assign cnt_en   = trig_q || trig_set;

  always_comb begin
    cnt_d  = cnt_q;
    trig_d = trig_q;
    unl_d  = unl_q;
    if (ctrl_we && !wr_data[B_STAT]) unl_d = 1'b0;
    if (trig_q) begin
      if (keys_ok) begin
        unl_d  = 1'b1;
        trig_d = 1'b0;
        cnt_d  = '0;
      end else if (cnt_q == CW'(1)) begin
        trig_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
    if (trig_set) begin
      trig_d = 1'b1;
      cnt_d  = CW'(TMO);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q  <= '0;
      trig_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      trig_q <= trig_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) unl_q <= 1'b0;
    else         unl_q <= unl_d;
  end

  assign trig     = trig_q;
  assign unlocked = unl_q;

  AST_UNLOCK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(unl_q) |-> $past(trig_q)) else $error("unlock outside window"); // R2
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_sn)
    trig_q |-> (cnt_q != '0) && (cnt_q <= CW'(TMO))) else $error("timer range"); // R3
  AST_TRIG_MODE: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(trig_q) |-> $past(wr_data[B_MHI:B_MLO]) == MD_UNLOCK) else $error("trigger in reserved mode"); // R9
endmodule

// File: rtl/fg_opctl.sv
module fg_opctl
  import fg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sn,
  input  logic       ctrl_we,
  input  logic [7:0] wr_data,
  input  logic       unlocked,
  input  logic       fl_done,
  output logic       wr_go,
  output logic       rd_go,
  output logic       fl_req,
  output logic [1:0] fl_op,
  output logic       ld_en
);
  logic       busy_q, busy_d, wgo_q, wgo_d, rgo_q, rgo_d, req_q, req_d;
  logic [1:0] op_q, op_d;
  logic [2:0] m_w;
  logic       acc_wr, acc_rd, unl_eff;

  assign m_w     = wr_data[B_MHI:B_MLO];
  assign unl_eff = unlocked && wr_data[B_STAT];
  assign acc_wr  = ctrl_we && !busy_q && wr_data[B_WGO] && unl_eff
                   && ((m_w == MD_WRITE) || (m_w == MD_ERASE));
  assign acc_rd  = ctrl_we && !busy_q && wr_data[B_RGO] && !wr_data[B_WGO]
                   && wr_data[B_REN] && (m_w == MD_READ);

  always_comb begin
    busy_d = busy_q;
    wgo_d  = wgo_q;
    rgo_d  = rgo_q;
    op_d   = op_q;
    req_d  = 1'b0;
    if (!busy_q) begin
      wgo_d = 1'b0;
      rgo_d = 1'b0;
      if (ctrl_we) begin
        wgo_d = wr_data[B_WGO];
        rgo_d = wr_data[B_RGO];
      end
      if (acc_wr) begin
        busy_d = 1'b1;
        req_d  = 1'b1;
        op_d   = (m_w == MD_ERASE) ? OP_ERASE : OP_WRITE;
      end else if (acc_rd) begin
        busy_d = 1'b1;
        req_d  = 1'b1;
        op_d   = OP_READ;
      end
    end else if (fl_done) begin
      busy_d = 1'b0;
      wgo_d  = 1'b0;
      rgo_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      busy_q <= 1'b0;
      wgo_q  <= 1'b0;
      rgo_q  <= 1'b0;
      req_q  <= 1'b0;
      op_q   <= OP_WRITE;
    end else begin
      busy_q <= busy_d;
      wgo_q  <= wgo_d;
      rgo_q  <= rgo_d;
      req_q  <= req_d;
      op_q   <= op_d;
    end
  end

  assign ld_en  = busy_q && fl_done && (op_q == OP_READ);
  assign wr_go  = wgo_q;
  assign rd_go  = rgo_q;
  assign fl_req = req_q;
  assign fl_op  = op_q;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_sn)
    req_q |=> !req_q) else $error("request longer than one cycle"); // R6
  AST_REQ_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_sn)
    req_q && (op_q != OP_READ) |-> unlocked) else $error("locked write or erase"); // R5
  AST_GO_HELD: assert property (@(posedge clk) disable iff (!rst_sn)
    busy_q && !fl_done && (op_q != OP_READ) |=> wgo_q) else $error("start bit dropped early"); // R6
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int          TMO  = 64,
  parameter logic [15:0] KEY1 = 16'h55AA,
  parameter logic [15:0] KEY2 = 16'hA55A,
  parameter logic [15:0] KEY3 = 16'h5AA5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [7:0]     wr_data,
  input  logic [RAW-1:0] rd_addr,
  output logic [7:0]     rd_data,
  output logic           fl_req,
  output logic [1:0]     fl_op,
  output logic [15:0]    fl_addr,
  output logic [15:0]    fl_wdata,
  input  logic [15:0]    fl_rdata,
  input  logic           fl_done
);
  logic [1:0]       rs_q;
  logic             rst_sn;
  logic             ctrl_we, ld_en, rd_en, trig, unlocked, wr_go, rd_go;
  logic [2:0]       mode;
  logic [15:0]      faddr;
  logic [2:0][15:0] pair;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  assign ctrl_we = wr_en && (wr_addr == OFS_CTRL);

  fg_regs #(.NPAIR(3)) u_regs (
    .clk(clk), .rst_sn(rst_sn), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ld_en(ld_en), .ld_data(fl_rdata), .mode(mode), .rd_en(rd_en), .faddr(faddr),
    .pair(pair)
  );

  fg_unlock #(.TMO(TMO), .KEY1(KEY1), .KEY2(KEY2), .KEY3(KEY3)) u_unlock (
    .clk(clk), .rst_sn(rst_sn), .ctrl_we(ctrl_we), .wr_data(wr_data), .mode(mode),
    .pair(pair), .trig(trig), .unlocked(unlocked)
  );

  fg_opctl u_opctl (
    .clk(clk), .rst_sn(rst_sn), .ctrl_we(ctrl_we), .wr_data(wr_data),
    .unlocked(unlocked), .fl_done(fl_done), .wr_go(wr_go), .rd_go(rd_go),
    .fl_req(fl_req), .fl_op(fl_op), .ld_en(ld_en)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_CTRL:  rd_data = {unlocked, mode, rd_en, rd_go, wr_go, trig};
      OFS_ALO:   rd_data = faddr[7:0];
      OFS_AHI:   rd_data = faddr[15:8];
      4'd3:      rd_data = pair[0][7:0];
      4'd4:      rd_data = pair[0][15:8];
      4'd5:      rd_data = pair[1][7:0];
      4'd6:      rd_data = pair[1][15:8];
      4'd7:      rd_data = pair[2][7:0];
      4'd8:      rd_data = pair[2][15:8];
      default:   rd_data = '0;
    endcase
  end

  assign fl_addr  = faddr;
  assign fl_wdata = pair[0];

  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_sn)
    fl_req && (fl_op == OP_READ) |-> rd_en && (mode == MD_READ)) else $error("ungated read"); // R8
  AST_NO_RSVD_REQ: assert property (@(posedge clk) disable iff (!rst_sn)
    fl_req |-> (mode == MD_WRITE) || (mode == MD_ERASE) || (mode == MD_READ)) else $error("request in reserved mode"); // R9
endmodule

// File: tb/tb_flash_guard.sv
module tb_flash_guard;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 64;

  logic        clk, rst_n, wr_en, fl_done, fl_req;
  logic [3:0]  wr_addr, rd_addr;
  logic [7:0]  wr_data, rd_data;
  logic [1:0]  fl_op;
  logic [15:0] fl_addr, fl_wdata, fl_rdata;

  int checks = 0, errors = 0, req_cnt = 0, dly = 0;
  bit finished = 0;

  flash_guard #(.TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fl_req(fl_req), .fl_op(fl_op),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_done(fl_done)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // array model: done three cycles after request
  always @(posedge clk) begin
    if (fl_req) begin
      req_cnt <= req_cnt + 1;
      dly <= 3;
    end else if (dly != 0) dly <= dly - 1;
    fl_done <= (dly == 1);
  end

  // addr, data, expected readback
  localparam logic [19:0] VEC [8] = '{
    {4'd1, 8'h34, 8'h34}, {4'd2, 8'h12, 8'h12}, {4'd3, 8'h0F, 8'h0F},
    {4'd4, 8'hF0, 8'hF0}, {4'd0, 8'h80, 8'h00}, {4'd0, 8'h08, 8'h08},
    {4'd0, 8'h70, 8'h70}, {4'd0, 8'h00, 8'h00}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rdchk(input logic [3:0] a, input logic [7:0] e, input string tag);
    rd_addr = a;
    #1;
    chk(rd_data == e, tag, rd_data, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rc;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; fl_rdata = 16'hBEEF;
    fl_done = 0;
    waitc(3);
    rst_n = 1;
    waitc(4);

    // R1 reset state
    for (int i = 0; i < 9; i++) rdchk(4'(i), 8'h00, "R1 reset reg");
    chk(fl_req == 0, "R1 reset req", fl_req, 0);

    // register vectors (R4: status bit write of 1 ignored; R8 read-enable bit)
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      rdchk(VEC[i][19:16], VEC[i][7:0], "R4 R8 vector readback");
    end

    // R9 trigger in reserved mode ignored
    wr(4'd0, 8'h51);
    rdchk(4'd0, 8'h50, "R9 reserved trigger");

    // R10 retrigger restarts timer
    wr(4'd0, 8'h61);
    waitc(40);
    rdchk(4'd0, 8'h61, "R10 first window");
    wr(4'd0, 8'h61);
    waitc(40);
    rdchk(4'd0, 8'h61, "R10 past first expiry");
    waitc(23);
    rdchk(4'd0, 8'h61, "R10 edge 63");
    waitc(1);
    rdchk(4'd0, 8'h60, "R10 expired");

    // R3 exact timeout and late keys
    wr(4'd0, 8'h61);
    waitc(TMO - 1);
    rdchk(4'd0, 8'h61, "R3 before expiry");
    waitc(1);
    rdchk(4'd0, 8'h60, "R3 at expiry");
    wr(4'd3, 8'hAA); wr(4'd4, 8'h55); wr(4'd5, 8'h5A); wr(4'd6, 8'hA5);
    wr(4'd7, 8'hA5); wr(4'd8, 8'h5A);
    waitc(2);
    rdchk(4'd0, 8'h60, "R3 late keys stay locked");

    // R2 unlock: break key 3 low, trigger, then fix within window
    wr(4'd7, 8'h00);
    wr(4'd0, 8'h61);
    waitc(2);
    rdchk(4'd0, 8'h61, "R2 not yet unlocked");
    wr(4'd7, 8'hA5);
    waitc(2);
    rdchk(4'd0, 8'hE0, "R2 unlocked");

    // R6 write
    rc = req_cnt;
    wr(4'd0, 8'h82);
    chk(fl_req == 1, "R6 req", fl_req, 1);
    chk(fl_op == 2'b00, "R6 op", fl_op, 0);
    chk(fl_addr == 16'h1234, "R6 addr", fl_addr, 16'h1234);
    chk(fl_wdata == 16'h55AA, "R6 wdata", fl_wdata, 16'h55AA);
    waitc(1);
    chk(fl_req == 0, "R6 one cycle", fl_req, 0);
    rdchk(4'd0, 8'h82, "R6 go held");
    waitc(8);
    rdchk(4'd0, 8'h80, "R6 go cleared");
    chk(req_cnt == rc + 1, "R6 one request", req_cnt, rc + 1);

    // R7 erase
    wr(4'd0, 8'h92);
    chk(fl_req == 1 && fl_op == 2'b01, "R7 erase op", {fl_req, fl_op}, 3'b101);
    waitc(8);
    rdchk(4'd0, 8'h90, "R7 go cleared");

    // R8 read
    wr(4'd0, 8'hBC);
    chk(fl_req == 1 && fl_op == 2'b10, "R8 read op", {fl_req, fl_op}, 3'b110);
    waitc(8);
    rdchk(4'd3, 8'hEF, "R8 latched low");
    rdchk(4'd4, 8'hBE, "R8 latched high");
    rdchk(4'd0, 8'hB8, "R8 start cleared");
    rc = req_cnt;
    wr(4'd0, 8'hB4);
    waitc(3);
    chk(req_cnt == rc, "R8 no read without enable", req_cnt, rc);

    // R9 reserved mode with start
    wr(4'd0, 8'hA2);
    waitc(3);
    chk(req_cnt == rc, "R9 reserved no request", req_cnt, rc);
    rdchk(4'd0, 8'hA0, "R9 start cleared");

    // R4 software relock, R5 locked write refused
    wr(4'd0, 8'h00);
    rdchk(4'd0, 8'h00, "R4 relock");
    wr(4'd0, 8'h02);
    rdchk(4'd0, 8'h02, "R5 start visible one cycle");
    chk(fl_req == 0, "R5 no req", fl_req, 0);
    waitc(1);
    rdchk(4'd0, 8'h00, "R5 start cleared");
    waitc(4);
    chk(req_cnt == rc, "R5 no request", req_cnt, rc);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule